// File: doc/BRIEF.md
# Fine/Coarse Hardware Thread Fetch Selector

This block decides which of several hardware threads feeds the next fetch slot of a shared pipeline. Each thread is represented only by its index, and each one reports two things: whether it is ready to fetch, and whether it is stalled. A stall also carries a class bit that marks it as long-latency, such as a miss that goes out to main memory.

A configuration input chooses between two scheduling policies. In interleaved (fine) mode the selector rotates to the next eligible thread on every cycle. Threads that are not ready, or that are stalled, are skipped. In blocked (coarse) mode the selector stays on one thread. A short stall only holds that thread's fetch. A long stall hands the pipeline to another eligible thread and raises a one-cycle flush, which tells the pipeline to discard the instructions already in flight from the old thread.

All outputs come from registers. They reflect the inputs sampled at the previous rising clock edge.

Top module: `thrd_sel`

## Requirements
- R1: While reset is asserted and at the first edge after it, tid_o is 0, fetch_valid_o is 0 and flush_o is 0.
- R2: In fine mode (mode_i = 0), a thread is eligible when its ready bit is 1 and its stall bit is 0. The next tid_o is the first eligible thread in the order cur+1, cur+2, …, with the current thread cur checked last. fetch_valid_o is then 1.
- R3: In fine mode, when no thread is eligible, tid_o keeps its value and fetch_valid_o is 0.
- R4: In fine mode, flush_o is always 0.
- R5: In coarse mode (mode_i = 1), when the current thread is not stalled, tid_o keeps its value and fetch_valid_o equals that thread's ready bit.
- R6: In coarse mode, a short stall on the current thread (stall bit 1, long bit 0) keeps tid_o, drives fetch_valid_o to 0, and causes no flush.
- R7: In coarse mode, a long stall on the current thread (stall bit 1, long bit 1) with another thread eligible switches tid_o to the first eligible other thread in round-robin order after cur. It sets fetch_valid_o to 1 and pulses flush_o high for exactly that one cycle.
- R8: In coarse mode, a long stall when no other thread is eligible keeps tid_o, drives fetch_valid_o to 0, and leaves flush_o at 0.
- R9: Each decision is made from the inputs present at a rising edge and appears on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = switch every cycle, 1 = switch on long stall |
| ready_i | input | NUM_THREADS | Per-thread fetch-ready bits |
| stall_i | input | NUM_THREADS | Per-thread stall bits |
| stall_long_i | input | NUM_THREADS | Per-thread stall class, 1 = long latency |
| tid_o | output | $clog2(NUM_THREADS) | Thread selected for fetch |
| fetch_valid_o | output | 1 | Selected thread fetches this cycle |
| flush_o | output | 1 | One-cycle pipeline flush on a coarse switch |

## Verification
The current-thread register is the only state. A wrong value in it shows up at once: tid_o is compared on every clock, and in both modes the next choice is computed from that register. A corrupted rotation point therefore sends fine mode to the wrong next thread within one cycle. In coarse mode a wrong held thread appears as a wrong tid_o, or as a missing or spurious flush, on the cycle that follows the stall.

// File: rtl/thrd_sel_pkg.sv
package thrd_sel_pkg;
  typedef enum logic {
    MODE_FINE   = 1'b0,
    MODE_COARSE = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/thrd_rr_pick.sv
// Round-robin search starting after base_i; base_i itself is checked last
// unless skip_base_i excludes it.
module thrd_rr_pick #(
  parameter int N = 4,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] base_i,
  input  logic         skip_base_i,
  output logic         found_o,
  output logic [W-1:0] pick_o
);
  always_comb begin
    found_o = 1'b0;
    pick_o  = base_i;
    for (int k = 1; k <= N; k++) begin
      int unsigned idx;
      idx = (int'(base_i) + k) % N;
      if (!found_o && req_i[idx] && !(skip_base_i && k == N)) begin
        found_o = 1'b1;
        pick_o  = idx[W-1:0];
      end
    end
  end
endmodule

// File: rtl/thrd_sel_policy.sv
module thrd_sel_policy
  import thrd_sel_pkg::*;
#(
  parameter int N = 4,
  parameter int W = $clog2(N)
) (
  input  sel_mode_e    mode_i,
  input  logic [W-1:0] cur_i,
  input  logic [N-1:0] elig_i,
  input  logic         cur_ready_i,
  input  logic         cur_stall_i,
  input  logic         cur_long_i,
  output logic [W-1:0] nxt_tid_o,
  output logic         nxt_valid_o,
  output logic         nxt_flush_o
);
  logic         found;
  logic [W-1:0] pick;

  thrd_rr_pick #(.N(N), .W(W)) u_pick (
    .req_i       (elig_i),
    .base_i      (cur_i),
    .skip_base_i (mode_i == MODE_COARSE),
    .found_o     (found),
    .pick_o      (pick)
  );

  always_comb begin
    nxt_tid_o   = cur_i;
    nxt_valid_o = 1'b0;
    nxt_flush_o = 1'b0;
    if (mode_i == MODE_FINE) begin
      if (found) begin
        nxt_tid_o   = pick;
        nxt_valid_o = 1'b1;
      end
    end else if (cur_stall_i && cur_long_i) begin
      if (found) begin
        nxt_tid_o   = pick;
        nxt_valid_o = 1'b1;
        nxt_flush_o = 1'b1;
      end
    end else if (!cur_stall_i) begin
      nxt_valid_o = cur_ready_i;
    end
  end
endmodule

// File: rtl/thrd_sel.sv
module thrd_sel
  import thrd_sel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_i,
  input  logic [NUM_THREADS-1:0] ready_i,
  input  logic [NUM_THREADS-1:0] stall_i,
  input  logic [NUM_THREADS-1:0] stall_long_i,
  output logic [TID_W-1:0]       tid_o,
  output logic                   fetch_valid_o,
  output logic                   flush_o
);
  logic [TID_W-1:0]       tid_q, nxt_tid;
  logic                   vld_q, nxt_vld;
  logic                   fl_q, nxt_fl;
  logic [NUM_THREADS-1:0] elig;

  assign elig = ready_i & ~stall_i;

  thrd_sel_policy #(.N(NUM_THREADS), .W(TID_W)) u_policy (
    .mode_i      (sel_mode_e'(mode_i)),
    .cur_i       (tid_q),
    .elig_i      (elig),
    .cur_ready_i (ready_i[tid_q]),
    .cur_stall_i (stall_i[tid_q]),
    .cur_long_i  (stall_long_i[tid_q]),
    .nxt_tid_o   (nxt_tid),
    .nxt_valid_o (nxt_vld),
    .nxt_flush_o (nxt_fl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tid_q <= '0;
      vld_q <= 1'b0;
      fl_q  <= 1'b0;
    end else begin
      tid_q <= nxt_tid;
      vld_q <= nxt_vld;
      fl_q  <= nxt_fl;
    end
  end

  assign tid_o         = tid_q;
  assign fetch_valid_o = vld_q;
  assign flush_o       = fl_q;

  // R4 R7
  flush_on_coarse_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> ($past(mode_i) && tid_o != $past(tid_o) && fetch_valid_o));

  // R5 R6
  coarse_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !(stall_i[tid_o] && stall_long_i[tid_o])) |=> ($stable(tid_o) && !flush_o));

  // R2
  valid_means_eligible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i) |=> (fetch_valid_o == $past(|(ready_i & ~stall_i))));

  // R3
  fine_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && (ready_i & ~stall_i) == '0) |=> ($stable(tid_o) && !fetch_valid_o));

  // R6
  short_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && stall_i[tid_o] && !stall_long_i[tid_o]) |=> !fetch_valid_o);
endmodule

// File: tb/thrd_sel_tb.sv
module thrd_sel_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode = 1'b0;
  logic [N-1:0] rdy = '0, stl = '0, lng = '0;
  logic [1:0]   tid;
  logic         fv, fl;

  int checks = 0, fails = 0;
  bit done = 0;
  int e_tid = 0, e_vld = 0, e_fl = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  thrd_sel #(.NUM_THREADS(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ready_i(rdy),
    .stall_i(stl), .stall_long_i(lng), .tid_o(tid),
    .fetch_valid_o(fv), .flush_o(fl)
  );

  task automatic compare();
    checks++;
    if (int'(tid) != e_tid || int'(fv) != e_vld || int'(fl) != e_fl) begin
      fails++;
      $display("FAIL %s: got tid=%0d vld=%0d fl=%0d exp tid=%0d vld=%0d fl=%0d",
               tag, tid, fv, fl, e_tid, e_vld, e_fl);
    end
  endtask

  // reference model: applied with the inputs present at the edge (R9)
  task automatic model_step();
    bit found = 0;
    int nxt = e_tid;
    int lim;
    logic [N-1:0] el = rdy & ~stl;
    lim = mode ? N - 1 : N;
    for (int k = 1; k <= lim; k++) begin
      int t = (e_tid + k) % N;
      if (!found && el[t]) begin found = 1; nxt = t; end
    end
    e_fl = 0;
    if (!mode) begin
      if (found) begin e_tid = nxt; e_vld = 1; tag = "R2/R4 fine rotate"; end
      else begin e_vld = 0; tag = "R3 fine idle"; end
    end else if (stl[e_tid] && lng[e_tid]) begin
      if (found) begin e_tid = nxt; e_vld = 1; e_fl = 1; tag = "R7 long switch"; end
      else begin e_vld = 0; tag = "R8 long no alternative"; end
    end else if (stl[e_tid]) begin
      e_vld = 0; tag = "R6 short stall";
    end else begin
      e_vld = int'(rdy[e_tid]); tag = "R5 coarse hold";
    end
  endtask

  task automatic cyc(input logic m, input logic [N-1:0] r, input logic [N-1:0] s,
                     input logic [N-1:0] l);
    mode = m; rdy = r; stl = s; lng = l;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    @(negedge clk);
    tag = "R1 in reset";
    rdy = '1;
    compare();
    @(negedge clk);
    rst_n = 1'b1;
    rdy = '0;
    // R1: first edge with nothing eligible keeps thread 0
    cyc(0, 4'b0000, 4'b0000, 4'b0000);
    // R2: full rotation 1,2,3,0
    for (int i = 0; i < 5; i++) cyc(0, 4'b1111, 4'b0000, 4'b0000);
    // R2: skip not-ready and stalled threads
    cyc(0, 4'b1010, 4'b0000, 4'b0000);
    cyc(0, 4'b1010, 4'b0000, 4'b0000);
    cyc(0, 4'b1111, 4'b0110, 4'b0000);
    // R2: a single ready thread keeps being chosen
    cyc(0, 4'b0100, 4'b0000, 4'b0000);
    cyc(0, 4'b0100, 4'b0000, 4'b0000);
    // R3
    cyc(0, 4'b0000, 4'b0000, 4'b0000);
    cyc(0, 4'b1111, 4'b1111, 4'b0000);
    // R4: long stalls in fine mode never flush
    cyc(0, 4'b1111, 4'b0001, 4'b1111);
    // R5: coarse holds
    cyc(1, 4'b1111, 4'b0000, 4'b0000);
    cyc(1, 4'b1111, 4'b0000, 4'b0000);
    cyc(1, 4'b0000, 4'b0000, 4'b0000);
    // R6: short stall on every thread
    cyc(1, 4'b1111, 4'b1111, 4'b0000);
    // R7: long stall, others eligible
    for (int i = 0; i < 4; i++) cyc(1, 4'b1111, 4'b1111 & ~(4'b0001 << ((e_tid + 1) % N)), 4'b1111);
    // R8: long stall with nothing else eligible
    cyc(1, 4'b1111, 4'b1111, 4'b1111);
    cyc(1, 4'b0000, 4'b1111, 4'b1111);
    // R7: back-to-back switches
    cyc(1, 4'b1111, 4'b0000, 4'b1111);
    for (int i = 0; i < 3; i++) cyc(1, 4'b1111, 4'b0001 << e_tid, 4'b1111);
    // mixed random traffic
    for (int i = 0; i < 3000; i++)
      cyc(logic'($urandom_range(0, 1)), N'($urandom), N'($urandom), N'($urandom));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule